// File: doc/BRIEF.md
# Serial EEPROM Word Reader

The block fetches 16-bit words from a three-wire serial configuration EEPROM. It drives the select, clock and data-in lines and samples the device's data-out line. A single start pulse carries a base word address, an address-length choice (6 or 8 address bits), a word count and a byte-swap option. The block then reads that many consecutive words. It hands each word out with a one-cycle valid strobe, and swaps its two bytes on request.

Inside, a clock-divided transfer engine performs one word read per select window. It raises select, shifts out a read command and the address most significant bit first, then clocks in 16 data bits and drops select. Each serial bit has a setup phase, a clock-high phase and a clock-low phase. The length of each phase is a parameter counted in system clock cycles. A burst controller around the engine steps the address, counts the words down and drives the busy flag. Software can use the block to read an identification word with the long address setting, and then choose the setting for later reads from that word.

Top module: `sprom_reader`

## Requirements
- R1: While reset is asserted and after it is released with no start, the outputs are at rest: `ee_cs`, `ee_sk`, `busy` and `word_valid` are all 0.
- R2: A `start` pulse sampled while `busy` is 0 with a nonzero `word_cnt` makes `busy` 1 in the following cycle. A `start` with `word_cnt` of 0 is ignored and `busy` stays 0.
- R3: A `start` pulse sampled while `busy` is 1 is ignored. The burst in progress keeps its address, count and swap setting, and no extra words are delivered.
- R4: Each select window sends a command of 1, 1, 0 followed by the word address, most significant bit first. With `addr_long`=1 the address is 8 bits (11 clock pulses). With `addr_long`=0 it is the low 6 bits of the address (9 clock pulses).
- R5: After the command, 16 data bits are clocked in most significant bit first. Each bit is the value of `ee_do` at the last system cycle of a clock-high phase.
- R6: Each serial bit holds `ee_sk` low for SETUP_CYC cycles, then high for HIGH_CYC cycles, then low for LOW_CYC cycles. `ee_di` does not change while `ee_sk` is high, and `ee_sk` is never high while `ee_cs` is low.
- R7: `ee_cs` rises SETUP_CYC cycles before the first setup phase. It stays high through the command and all 16 data pulses, and falls after the LOW_CYC low phase that follows the 16th data pulse.
- R8: A burst reads `word_cnt` consecutive addresses starting at `base_addr`, wrapping within the selected address width. The words are delivered in order, each with `word_valid` high for exactly one cycle.
- R9: With `swap_en`=1 at start, each delivered word has its upper and lower bytes exchanged. With `swap_en`=0 the word is delivered as read.
- R10: `busy` falls in the cycle where the last word's `word_valid` is high. A one-word burst keeps `busy` high for SETUP_CYC + (3 + address bits + 16) x (SETUP_CYC + HIGH_CYC + LOW_CYC) + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a burst |
| base_addr | input | LONG_AW | First word address of the burst |
| addr_long | input | 1 | 1 selects 8 address bits, 0 selects 6 |
| word_cnt | input | CNT_W | Number of words to read; 0 is ignored |
| swap_en | input | 1 | Exchange the two bytes of each word |
| busy | output | 1 | Burst in progress |
| word_valid | output | 1 | One-cycle strobe for each delivered word |
| word_data | output | WORD_W | Delivered word |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
Three cases are the hardest to reach from the ports. The first is a start pulse that lands in the middle of a burst with different settings. The second is a burst whose addresses wrap at the edge of the 6-bit space. The third is a burst whose addresses wrap at the edge of the 8-bit space. The bench pulses start again several hundred cycles into a running burst and checks that the addresses decoded by its serial EEPROM model and the number of words delivered stay as first requested. Bases near the top of each address space force the wrap. A behavioural busy and word model, plus clock-phase run-length counters, is compared on every clock edge.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

   // serial command prefix: start bit followed by the read opcode
   localparam logic [2:0] READ_OPC = 3'b110;
   localparam int         OPC_W    = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEL,
      ST_CMD,
      ST_DATA
   } stage_e;

   typedef enum logic [1:0] {
      PH_SET,
      PH_HIGH,
      PH_LOW
   } phase_e;

endpackage

// File: rtl/sprom_xfer.sv
module sprom_xfer
   import sprom_pkg::*;
#(
   parameter int LONG_AW   = 8,
   parameter int SHORT_AW  = 6,
   parameter int WORD_W    = 16,
   parameter int SETUP_CYC = 2,
   parameter int HIGH_CYC  = 3,
   parameter int LOW_CYC   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [LONG_AW-1:0] addr,
   input  logic               addr_long,
   output logic               done,
   output logic [WORD_W-1:0]  rdata,
   output logic               ee_cs,
   output logic               ee_sk,
   output logic               ee_di,
   input  logic               ee_do
);

   localparam int CMD_W   = OPC_W + LONG_AW;
   localparam int CMD_S   = OPC_W + SHORT_AW;
   localparam int AW_DIFF = LONG_AW - SHORT_AW;
   localparam int MAX_HL  = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
   localparam int MAXC    = (SETUP_CYC > MAX_HL) ? SETUP_CYC : MAX_HL;
   localparam int PC_W    = $clog2(MAXC + 1);
   localparam int MAXB    = (CMD_W > WORD_W) ? CMD_W : WORD_W;
   localparam int BC_W    = $clog2(MAXB + 1);

   localparam logic [PC_W-1:0] SET_LD = PC_W'(SETUP_CYC - 1);
   localparam logic [PC_W-1:0] HI_LD  = PC_W'(HIGH_CYC - 1);
   localparam logic [PC_W-1:0] LO_LD  = PC_W'(LOW_CYC - 1);

   stage_e             stage;
   phase_e             phase;
   logic [PC_W-1:0]    pcnt;
   logic [BC_W-1:0]    bcnt;
   logic [CMD_W-1:0]   cmd_sr;
   logic [WORD_W-1:0]  data_sr;
   logic [CMD_W-1:0]   cmd_word;
   logic               shifting;

   // short addresses are left-aligned so the same shifter serves both lengths
   assign cmd_word = {READ_OPC, addr_long ? addr : (addr << AW_DIFF)};
   assign shifting = (stage == ST_CMD) || (stage == ST_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage   <= ST_IDLE;
         phase   <= PH_SET;
         pcnt    <= '0;
         bcnt    <= '0;
         cmd_sr  <= '0;
         data_sr <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (stage)
            ST_IDLE: begin
               if (go) begin
                  stage  <= ST_SEL;
                  pcnt   <= SET_LD;
                  cmd_sr <= cmd_word;
                  bcnt   <= addr_long ? BC_W'(CMD_W - 1) : BC_W'(CMD_S - 1);
               end
            end
            ST_SEL: begin
               if (pcnt == '0) begin
                  stage <= ST_CMD;
                  phase <= PH_SET;
                  pcnt  <= SET_LD;
               end else begin
                  pcnt <= pcnt - 1'b1;
               end
            end
            default: begin
               if (pcnt != '0) begin
                  pcnt <= pcnt - 1'b1;
               end else begin
                  case (phase)
                     PH_SET: begin
                        phase <= PH_HIGH;
                        pcnt  <= HI_LD;
                     end
                     PH_HIGH: begin
                        phase <= PH_LOW;
                        pcnt  <= LO_LD;
                        if (stage == ST_DATA)
                           data_sr <= {data_sr[WORD_W-2:0], ee_do};
                     end
                     PH_LOW: begin
                        phase <= PH_SET;
                        pcnt  <= SET_LD;
                        if (bcnt == '0) begin
                           if (stage == ST_CMD) begin
                              stage <= ST_DATA;
                              bcnt  <= BC_W'(WORD_W - 1);
                           end else begin
                              stage <= ST_IDLE;
                              done  <= 1'b1;
                           end
                        end else begin
                           bcnt   <= bcnt - 1'b1;
                           cmd_sr <= {cmd_sr[CMD_W-2:0], 1'b0};
                        end
                     end
                     default: phase <= PH_SET;
                  endcase
               end
            end
         endcase
      end
   end

   assign ee_cs = (stage != ST_IDLE);
   assign ee_sk = shifting && (phase == PH_HIGH);
   assign ee_di = (stage == ST_CMD) && cmd_sr[CMD_W-1];
   assign rdata = data_sr;

endmodule

// File: rtl/sprom_byte_order.sv
module sprom_byte_order #(
   parameter int WORD_W       = 16,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic [WORD_W-1:0] din,
   input  logic              swap_en,
   output logic [WORD_W-1:0] dout
);

   localparam int HALF = WORD_W / 2;

   generate
      if (SWAP_SUPPORT) begin : g_swap
         assign dout = swap_en ? {din[HALF-1:0], din[WORD_W-1:HALF]} : din;
      end else begin : g_pass
         logic unused_swap;
         assign unused_swap = swap_en;
         assign dout        = din;
      end
   endgenerate

endmodule

// File: rtl/sprom_burst.sv
module sprom_burst #(
   parameter int LONG_AW      = 8,
   parameter int SHORT_AW     = 6,
   parameter int CNT_W        = 4,
   parameter int WORD_W       = 16,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LONG_AW-1:0] base_addr,
   input  logic               addr_long,
   input  logic [CNT_W-1:0]   word_cnt,
   input  logic               swap_en,
   output logic               eng_go,
   output logic [LONG_AW-1:0] eng_addr,
   output logic               eng_long,
   input  logic               eng_done,
   input  logic [WORD_W-1:0]  eng_data,
   output logic               busy,
   output logic               word_valid,
   output logic [WORD_W-1:0]  word_data
);

   localparam logic [LONG_AW-1:0] SHORT_MASK = LONG_AW'((1 << SHORT_AW) - 1);

   logic [CNT_W-1:0]   remain;
   logic [LONG_AW-1:0] cur_addr;
   logic [LONG_AW-1:0] cur_mask;
   logic [LONG_AW-1:0] load_mask;
   logic               long_q;
   logic               swap_q;
   logic [WORD_W-1:0]  ordered;

   assign cur_mask  = long_q    ? '1 : SHORT_MASK;
   assign load_mask = addr_long ? '1 : SHORT_MASK;

   sprom_byte_order #(
      .WORD_W       (WORD_W),
      .SWAP_SUPPORT (SWAP_SUPPORT)
   ) u_order (
      .din     (eng_data),
      .swap_en (swap_q),
      .dout    (ordered)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         remain     <= '0;
         cur_addr   <= '0;
         long_q     <= 1'b0;
         swap_q     <= 1'b0;
         eng_go     <= 1'b0;
         word_valid <= 1'b0;
         word_data  <= '0;
      end else begin
         eng_go     <= 1'b0;
         word_valid <= 1'b0;
         if (!busy) begin
            if (start && (word_cnt != '0)) begin
               busy     <= 1'b1;
               remain   <= word_cnt;
               cur_addr <= base_addr & load_mask;
               long_q   <= addr_long;
               swap_q   <= swap_en;
               eng_go   <= 1'b1;
            end
         end else if (eng_done) begin
            word_valid <= 1'b1;
            word_data  <= ordered;
            if (remain == CNT_W'(1)) begin
               busy <= 1'b0;
            end else begin
               remain   <= remain - 1'b1;
               cur_addr <= (cur_addr + 1'b1) & cur_mask;
               eng_go   <= 1'b1;
            end
         end
      end
   end

   assign eng_addr = cur_addr;
   assign eng_long = long_q;

endmodule

// File: rtl/sprom_reader.sv
module sprom_reader #(
   parameter int LONG_AW      = 8,
   parameter int SHORT_AW     = 6,
   parameter int CNT_W        = 4,
   parameter int WORD_W       = 16,
   parameter int SETUP_CYC    = 2,
   parameter int HIGH_CYC     = 3,
   parameter int LOW_CYC      = 2,
   parameter bit SWAP_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LONG_AW-1:0] base_addr,
   input  logic               addr_long,
   input  logic [CNT_W-1:0]   word_cnt,
   input  logic               swap_en,
   output logic               busy,
   output logic               word_valid,
   output logic [WORD_W-1:0]  word_data,
   output logic               ee_cs,
   output logic               ee_sk,
   output logic               ee_di,
   input  logic               ee_do
);

   generate
      if (SHORT_AW < 1 || SHORT_AW >= LONG_AW) begin : g_bad_aw
         $error("sprom_reader: SHORT_AW must lie in 1..LONG_AW-1");
      end
      if (WORD_W < 2 || (WORD_W % 2) != 0) begin : g_bad_word
         $error("sprom_reader: WORD_W must be even and at least 2");
      end
      if (SETUP_CYC < 1 || HIGH_CYC < 1 || LOW_CYC < 1) begin : g_bad_cyc
         $error("sprom_reader: every phase needs at least one cycle");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("sprom_reader: CNT_W must be at least 1");
      end
   endgenerate

   logic               eng_go;
   logic [LONG_AW-1:0] eng_addr;
   logic               eng_long;
   logic               eng_done;
   logic [WORD_W-1:0]  eng_data;

   sprom_burst #(
      .LONG_AW      (LONG_AW),
      .SHORT_AW     (SHORT_AW),
      .CNT_W        (CNT_W),
      .WORD_W       (WORD_W),
      .SWAP_SUPPORT (SWAP_SUPPORT)
   ) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .base_addr  (base_addr),
      .addr_long  (addr_long),
      .word_cnt   (word_cnt),
      .swap_en    (swap_en),
      .eng_go     (eng_go),
      .eng_addr   (eng_addr),
      .eng_long   (eng_long),
      .eng_done   (eng_done),
      .eng_data   (eng_data),
      .busy       (busy),
      .word_valid (word_valid),
      .word_data  (word_data)
   );

   sprom_xfer #(
      .LONG_AW   (LONG_AW),
      .SHORT_AW  (SHORT_AW),
      .WORD_W    (WORD_W),
      .SETUP_CYC (SETUP_CYC),
      .HIGH_CYC  (HIGH_CYC),
      .LOW_CYC   (LOW_CYC)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (eng_go),
      .addr      (eng_addr),
      .addr_long (eng_long),
      .done      (eng_done),
      .rdata     (eng_data),
      .ee_cs     (ee_cs),
      .ee_sk     (ee_sk),
      .ee_di     (ee_di),
      .ee_do     (ee_do)
   );

endmodule

// File: rtl/sprom_reader_chk.sv
module sprom_reader_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic word_valid,
   input logic ee_cs,
   input logic ee_sk,
   input logic ee_di
);

   // R6
   sk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ee_cs |-> !ee_sk);

   // R6
   di_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

   // R7
   cs_drop_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_cs) |-> !$past(ee_sk));

   // R2
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R10
   busy_ends_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> word_valid);

   // R8
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

endmodule

bind sprom_reader sprom_reader_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .word_valid (word_valid),
   .ee_cs      (ee_cs),
   .ee_sk      (ee_sk),
   .ee_di      (ee_di)
);

// File: tb/sprom_reader_test.sv
`timescale 1ns/100ps
module sprom_reader_test;

   localparam int S = 2;
   localparam int H = 3;
   localparam int L = 2;
   localparam int P = S + H + L;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  base_addr = '0;
   logic        addr_long = 1'b0;
   logic [3:0]  word_cnt = '0;
   logic        swap_en = 1'b0;
   logic        busy;
   logic        word_valid;
   logic [15:0] word_data;
   logic        ee_cs;
   logic        ee_sk;
   logic        ee_di;
   logic        ee_do = 1'b0;

   int vectors = 0;
   int miscomp = 0;
   string tag = "R8";

   always #2.5 clk = ~clk;

   sprom_reader #(
      .SETUP_CYC (S),
      .HIGH_CYC  (H),
      .LOW_CYC   (L)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .base_addr  (base_addr),
      .addr_long  (addr_long),
      .word_cnt   (word_cnt),
      .swap_en    (swap_en),
      .busy       (busy),
      .word_valid (word_valid),
      .word_data  (word_data),
      .ee_cs      (ee_cs),
      .ee_sk      (ee_sk),
      .ee_di      (ee_di),
      .ee_do      (ee_do)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         miscomp++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mem_word(input int a);
      return 16'((a * 40503) ^ 16'h5AC3 ^ (a << 9));
   endfunction

   // ---------------- reference model state ----------------
   logic [15:0] exp_q[$];
   int          addr_q[$];
   int          outstanding = 0;
   int          ee_n = 11;

   // ---------------- serial EEPROM model ----------------
   int          ee_bits = 0;
   int          ee_cmd  = 0;
   logic [15:0] ee_word = '0;

   always @(posedge ee_sk or negedge ee_cs) begin
      if (!ee_cs) begin
         if (ee_bits != 0)
            chk(ee_bits == ee_n + 16, "R7", "clock pulses per select", ee_bits, ee_n + 16);
         ee_bits = 0;
         ee_cmd  = 0;
         ee_do   = 1'b0;
      end else begin
         ee_bits++;
         if (ee_bits <= ee_n)
            ee_cmd = (ee_cmd << 1) | int'(ee_di);
         if (ee_bits == ee_n) begin
            int opc;
            int a;
            int ea;
            opc = (ee_cmd >> (ee_n - 3)) & 7;
            a   = ee_cmd & ((1 << (ee_n - 3)) - 1);
            chk(opc == 6, "R4", "command prefix", opc, 6);
            ea = (addr_q.size() != 0) ? addr_q.pop_front() : -1;
            chk(a == ea, "R4", "decoded address", a, ea);
            ee_word = mem_word(a);
         end
         if (ee_bits > ee_n && ee_bits <= ee_n + 16)
            ee_do = ee_word[ee_n + 16 - ee_bits];
      end
   end

   // ---------------- per-clock comparison ----------------
   logic prev_sk = 1'b0;
   logic prev_cs = 1'b0;
   logic prev_di = 1'b0;
   int   hi_run = 0;
   int   lo_run = 0;
   int   busy_run = 0;
   int   last_busy_len = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (word_valid) begin
            logic [15:0] e;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'hxxxx;
            chk(word_data === e, tag, "delivered word", word_data, e);
            if (outstanding > 0) outstanding--;
            else chk(1'b0, "R3", "unexpected word", word_data, 0);
         end
         chk(busy == (outstanding > 0), "R10", "busy", busy, outstanding > 0);
         if (!ee_cs)
            chk(!ee_sk, "R6", "clock outside select", ee_sk, 0);
         if (ee_sk && prev_sk)
            chk(ee_di == prev_di, "R6", "data-in moved while clock high", ee_di, prev_di);
         if (ee_sk) begin
            hi_run++;
            lo_run = 0;
         end else begin
            if (prev_sk) chk(hi_run == H, "R6", "clock-high length", hi_run, H);
            hi_run = 0;
            if (ee_cs) lo_run++;
         end
         if (!ee_cs && prev_cs)
            chk(lo_run == L, "R7", "low cycles before deselect", lo_run, L);
         if (!ee_cs) lo_run = 0;
         if (busy) busy_run++;
         else if (busy_run != 0) begin
            last_busy_len = busy_run;
            busy_run = 0;
         end
         // start accepted at the coming edge
         if (start && outstanding == 0 && word_cnt != 0) begin
            int aw;
            aw = addr_long ? 8 : 6;
            ee_n = 3 + aw;
            outstanding = int'(word_cnt);
            for (int i = 0; i < int'(word_cnt); i++) begin
               int a;
               logic [15:0] w;
               a = (int'(base_addr) + i) & ((1 << aw) - 1);
               w = mem_word(a);
               addr_q.push_back(a);
               exp_q.push_back(swap_en ? {w[7:0], w[15:8]} : w);
            end
         end
      end
      prev_sk = ee_sk;
      prev_cs = ee_cs;
      prev_di = ee_di;
   end

   // ---------------- stimulus ----------------
   task automatic pulse_start(input logic [7:0] b, input bit lng, input int n, input bit sw);
      @(posedge clk); #1;
      base_addr = b;
      addr_long = lng;
      word_cnt  = 4'(n);
      swap_en   = sw;
      start     = 1'b1;
      @(posedge clk); #1;
      start     = 1'b0;
   endtask

   task automatic wait_idle();
      int guard;
      guard = 0;
      @(negedge clk);
      while (busy && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, tag, "words still expected", exp_q.size(), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscomp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

   initial begin
      // R1: outputs at rest during and after reset
      repeat (3) @(negedge clk);
      chk({ee_cs, ee_sk, busy, word_valid} == 4'b0, "R1", "rest during reset",
          {ee_cs, ee_sk, busy, word_valid}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({ee_cs, ee_sk, busy, word_valid} == 4'b0, "R1", "rest after reset",
          {ee_cs, ee_sk, busy, word_valid}, 0);

      // R10 R5: one word, long address
      tag = "R5";
      pulse_start(8'h5A, 1'b1, 1, 1'b0);
      wait_idle();
      chk(last_busy_len == S + 27 * P + 2, "R10", "busy length long", last_busy_len, S + 27 * P + 2);

      // R4: one word, short address takes the low 6 bits
      tag = "R4";
      pulse_start(8'hC7, 1'b0, 1, 1'b0);
      wait_idle();
      chk(last_busy_len == S + 25 * P + 2, "R10", "busy length short", last_busy_len, S + 25 * P + 2);

      // R8 R9: long burst wrapping past the top, swapped
      tag = "R9";
      pulse_start(8'hFE, 1'b1, 4, 1'b1);
      wait_idle();

      // R8: short burst wrapping inside 6 bits
      tag = "R8";
      pulse_start(8'h3E, 1'b0, 3, 1'b0);
      wait_idle();

      // R3: second start during a burst is ignored
      tag = "R3";
      pulse_start(8'h10, 1'b1, 2, 1'b0);
      repeat (300) @(posedge clk);
      pulse_start(8'h80, 1'b0, 7, 1'b1);
      wait_idle();

      // R2: zero count is ignored
      tag = "R2";
      pulse_start(8'h22, 1'b1, 0, 1'b0);
      repeat (5) @(negedge clk);
      chk(busy == 1'b0 && ee_cs == 1'b0, "R2", "zero count started", {busy, ee_cs}, 0);

      // R8 R9: longest burst, short address, swapped
      tag = "R8";
      pulse_start(8'h35, 1'b0, 15, 1'b1);
      wait_idle();

      // R9: unswapped after a swapped burst
      tag = "R9";
      pulse_start(8'h01, 1'b1, 2, 1'b0);
      wait_idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

endmodule